// File: doc/BRIEF.md
# Round-robin crossbar gate scheduler

This block drives the sixteen gate-enable lines of a four-input, four-output broadcast-and-select switch. Each enable line belongs to one input-to-output path. The only schedule control is an external slot clock, which may arrive with any spacing. The block brings that clock into the system clock domain and steps a one-hot ring of slot states on every rising edge it detects. From the current slot it builds a conflict-free input-to-output permutation, so that over four slots every output is joined once to every input.

At every slot transition all gates are first blanked for a programmable number of system-clock cycles, the guard band. After that the gates of the new permutation switch on. A per-path disable mask holds known-bad paths off without changing the rotation. A two-bit slot index and a one-cycle slot-start pulse show the schedule position.

Top module: `xbar_gate_sched`

## Requirements
- R1: While reset is held and after it is released, every enable is low, the slot index is 0 and the slot-start pulse is low. The enables stay low until the first slot-clock rising edge has been processed.
- R2: The slot clock passes through a two-flop synchronizer, and only its rising edges count. The outputs respond on the third system-clock rising edge after the slot clock rises. A slot clock held high for any length of time causes exactly one step.
- R3: The first processed edge starts slot 0. Each later edge advances the slot index by one, and the index wraps from 3 back to 0.
- R4: Enable bit gate_en[4*o + i] joins 0-based input i to 0-based output o. In slot s, output o is joined to input (3 - o - s) mod 4, so output 0 sees inputs 3, 2, 1, 0 and then 3 again.
- R5: With no mask, each output has exactly one enable set and each input has at most one enable set.
- R6: After each processed edge, all enables are low for guard_len system-clock cycles, and then the new slot's permutation is driven. A guard_len of 0 switches straight to the new permutation with no blank cycle.
- R7: A set bit in path_mask forces that enable low from the next system-clock edge onward. The mask does not alter the slot order.
- R8: slot_start is high for exactly one cycle, in the same cycle as the slot index takes its new value.
- R9: The time between slot edges can be irregular. Each edge is processed on its own, whatever the high and low times of the slot clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_clk | input | 1 | Asynchronous slot clock; each rising edge starts a slot |
| guard_len | input | 8 | Blanking length in system-clock cycles, sampled at the slot edge |
| path_mask | input | 16 | Per-path force-off mask, same bit order as gate_en |
| gate_en | output | 16 | Gate enables, bit 4*output + input |
| slot_idx | output | 2 | Current slot number |
| slot_start | output | 1 | One-cycle pulse when a new slot begins |

## Verification
The bench raises the slot clock on a falling system-clock edge. It expects slot_idx, slot_start and the blanked enables to be sampled on the falling edge that follows the third rising edge. The permutation is then expected exactly guard_len falling edges later. Mask changes are checked one cycle after they are applied, and a held-high slot clock is watched for several cycles to confirm that nothing moves. Every sample is taken on a falling edge, halfway between the register updates.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;

    localparam int XS_PORTS_DEF   = 4;
    localparam int XS_GUARD_W_DEF = 8;

    // Source input feeding output o during slot s of an n-port rotation
    function automatic int src_port(input int o, input int s, input int n);
        return (2 * n - 1 - o - s) % n;
    endfunction

endpackage

// File: rtl/slot_edge_sync.sv
module slot_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = async_i;
        sy_d.sync = sy_q.meta;
        sy_d.prev = sy_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise_o = sy_q.sync & ~sy_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/slot_ring.sv
module slot_ring #(
    parameter int N_SLOTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    output logic [N_SLOTS-1:0] ring_o,
    output logic [N_SLOTS-1:0] ring_nxt_o
);
    logic [N_SLOTS-1:0] ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (step_i) ring_d = {ring_q[N_SLOTS-2:0], ring_q[N_SLOTS-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= N_SLOTS'(1);
        else        ring_q <= ring_d;
    end

    assign ring_o     = ring_q;
    assign ring_nxt_o = ring_d;

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring_q) == 1); // R3

endmodule

// File: rtl/gate_perm_map.sv
module gate_perm_map
    import xbar_sched_pkg::*;
#(
    parameter int N_PORTS = 4,
    localparam int NPATH  = N_PORTS * N_PORTS,
    localparam int SLOT_W = $clog2(N_PORTS)
) (
    input  logic [SLOT_W-1:0] slot_i,
    output logic [NPATH-1:0]  en_o
);
    always_comb begin
        en_o = '0;
        for (int o = 0; o < N_PORTS; o++) begin
            for (int i = 0; i < N_PORTS; i++) begin
                en_o[o * N_PORTS + i] = (src_port(o, int'(slot_i), N_PORTS) == i);
            end
        end
    end

endmodule

// File: rtl/xbar_gate_sched.sv
module xbar_gate_sched
    import xbar_sched_pkg::*;
#(
    parameter int N_PORTS  = XS_PORTS_DEF,
    parameter int GUARD_W  = XS_GUARD_W_DEF,
    localparam int NPATH   = N_PORTS * N_PORTS,
    localparam int SLOT_W  = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_clk,
    input  logic [GUARD_W-1:0] guard_len,
    input  logic [NPATH-1:0]   path_mask,
    output logic [NPATH-1:0]   gate_en,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic               slot_start
);
    typedef struct packed {
        logic               started;
        logic               start;
        logic [GUARD_W-1:0] cnt;
        logic [NPATH-1:0]   gates;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               slot_rise;
    logic [N_PORTS-1:0] ring_cur, ring_nxt;
    logic [SLOT_W-1:0]  idx_cur, idx_nxt;
    logic [NPATH-1:0]   perm_en;

    slot_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (slot_clk),
        .rise_o  (slot_rise)
    );

    slot_ring #(.N_SLOTS(N_PORTS)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (slot_rise & ctl_q.started),
        .ring_o     (ring_cur),
        .ring_nxt_o (ring_nxt)
    );

    always_comb begin
        idx_cur = '0;
        idx_nxt = '0;
        for (int k = 0; k < N_PORTS; k++) begin
            if (ring_cur[k]) idx_cur = idx_cur | SLOT_W'(k);
            if (ring_nxt[k]) idx_nxt = idx_nxt | SLOT_W'(k);
        end
    end

    gate_perm_map #(.N_PORTS(N_PORTS)) u_map (
        .slot_i (idx_nxt),
        .en_o   (perm_en)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = slot_rise;
        if (slot_rise) begin
            ctl_d.started = 1'b1;
            ctl_d.cnt     = guard_len;
        end else if (ctl_q.cnt != '0) begin
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
        if (ctl_d.started && ctl_d.cnt == '0) ctl_d.gates = perm_en & ~path_mask;
        else                                  ctl_d.gates = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign gate_en    = ctl_q.gates;
    assign slot_idx   = idx_cur;
    assign slot_start = ctl_q.start;

    AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.started |-> gate_en == '0); // R1

    AST_GUARD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cnt != '0) |-> gate_en == '0); // R6

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start); // R8

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |-> slot_idx == $past(slot_idx)); // R8

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && $past(ctl_q.started))
            |-> slot_idx == SLOT_W'(($past(slot_idx) + 1) % N_PORTS)); // R3

    for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
        logic [N_PORTS-1:0] col;
        for (genvar h = 0; h < N_PORTS; h++) begin : g_col
            assign col[h] = gate_en[h * N_PORTS + g];
        end
        AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gate_en[g * N_PORTS +: N_PORTS]) <= 1); // R5
        AST_IN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) <= 1); // R5
    end

endmodule

// File: tb/xbar_gate_sched_tb.sv
module xbar_gate_sched_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_clk = 1'b0;
    logic [7:0]  guard_len = '0;
    logic [15:0] path_mask = '0;
    logic [15:0] gate_en;
    logic [1:0]  slot_idx;
    logic        slot_start;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xbar_gate_sched dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_clk   (slot_clk),
        .guard_len  (guard_len),
        .path_mask  (path_mask),
        .gate_en    (gate_en),
        .slot_idx   (slot_idx),
        .slot_start (slot_start)
    );

    function automatic logic [15:0] exp_gates(input int s, input logic [15:0] m);
        logic [15:0] r = '0;
        for (int o = 0; o < 4; o++) r[o * 4 + ((7 - o - s) % 4)] = 1'b1;
        return r & ~m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        slot_clk = 1'b0;
        path_mask = '0;
        repeat (4) @(negedge clk);
        chk("R1 reset gates", 32'(gate_en), 0);
        chk("R1 reset slot", 32'(slot_idx), 0);
        chk("R1 reset pulse", 32'(slot_start), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 idle gates before first edge", 32'(gate_en), 0);
    endtask

    // One slot edge; returns after the new permutation is visible
    task automatic slot_edge(input int s, input int g, input int low_cyc);
        slot_clk = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 R8 slot_start at third edge", 32'(slot_start), 1);
        chk("R3 slot index", 32'(slot_idx), 32'(s));
        if (g == 0) begin
            chk("R6 R4 zero guard direct switch", 32'(gate_en), 32'(exp_gates(s, path_mask)));
        end else begin
            chk("R6 blank first guard cycle", 32'(gate_en), 0);
            for (int j = 1; j <= g; j++) begin
                @(negedge clk);
                if (j == 1) chk("R8 pulse one cycle", 32'(slot_start), 0);
                if (j < g) chk("R6 blank in guard", 32'(gate_en), 0);
                else chk("R4 R6 permutation after guard", 32'(gate_en), 32'(exp_gates(s, path_mask)));
            end
        end
        // slot clock held high: nothing may move
        repeat (4) @(negedge clk);
        chk("R2 held high no step", 32'(slot_idx), 32'(s));
        chk("R2 held high gates stable", 32'(gate_en), 32'(exp_gates(s, path_mask)));
        if (path_mask == '0) begin
            for (int o = 0; o < 4; o++)
                chk("R5 one input per output", 32'($countones(gate_en[o * 4 +: 4])), 1);
            for (int i = 0; i < 4; i++)
                chk("R5 one output per input",
                    32'(gate_en[i] + gate_en[4 + i] + gate_en[8 + i] + gate_en[12 + i]), 1);
        end
        slot_clk = 1'b0;
        repeat (low_cyc) @(negedge clk);
    endtask

    initial begin
        automatic int guards[4] = '{0, 1, 3, 6};
        @(negedge clk);
        foreach (guards[gi]) begin
            do_reset();
            guard_len = 8'(guards[gi]);
            for (int k = 0; k < 9; k++) begin
                // R9: irregular low times between edges
                slot_edge(k % 4, guards[gi], 3 + (k * 7 + gi) % 11);
                // R7: change the mask mid-slot, visible one edge later
                path_mask = (k % 3 == 1) ? 16'h8421 : ((k % 3 == 2) ? 16'h1248 : 16'h0000);
                @(negedge clk);
                chk("R7 mask applied next cycle", 32'(gate_en), 32'(exp_gates(k % 4, path_mask)));
                chk("R7 mask keeps slot", 32'(slot_idx), 32'(k % 4));
            end
            path_mask = '0;
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule